// File: doc/BRIEF.md
# Masked Interrupt Pin Controller

This block gathers a set of interrupt event lines (eight by default) into sticky status bits. A rising edge on an event line sets its bit. A per-source enable mask gates the pending bits onto a single shared interrupt pin. The pin is modelled as a value output plus an output-enable, so the surrounding pad logic can build a true tristate. When no enabled bit is pending, the pin is released. Its asserted level comes from a programmable polarity bit.

Software reaches the block through a small register port with two registers:
- The interrupt register carries the enables in its upper half and the status bits in its lower half. Reading it clears the status bits.
- The control register holds the polarity bit.

A two-state machine owns the pin:
- PIN_RELEASED is the reset state, with the output-enable low.
- The *assert transition* moves to PIN_DRIVING on the clock edge after any enabled status bit is found set.
- In PIN_DRIVING the pin is driven to the active level.
- The *release transition* returns to PIN_RELEASED on the first edge at which no enabled bit remains pending.

Top module: `irq_pin_ctrl`

## Requirements
- R1: After reset all enables, the polarity bit and all status bits are 0. The control register reads 0x0000, the interrupt register reads 0x0000, and `irq_oe_o` is 0.
- R2: A 0-to-1 change on `evt_i[i]` sets status bit i (bit i of the interrupt register) at the next clock edge. An event level held high does not set the bit again after it has been cleared, and a set bit stays set until a clearing read.
- R3: A read (`reg_rd_i` high) of the interrupt register returns {enables[15:8], status[7:0]} and clears all status bits at that clock edge.
- R4: If a rising event on bit i arrives in the same cycle as a clearing read, bit i remains set afterwards. Other bits are still cleared.
- R5: A write to the interrupt register loads the enables from write-data bits 15:8. Write-data bits 7:0 have no effect on the status bits.
- R6: The assert transition (PIN_RELEASED to PIN_DRIVING) happens on the clock edge after (status AND enables) becomes nonzero, and `irq_oe_o` is 1 in PIN_DRIVING.
- R7: The release transition (PIN_DRIVING to PIN_RELEASED) happens on the clock edge after (status AND enables) becomes zero, and `irq_oe_o` is then 0.
- R8: Control bit 0 is the polarity: 1 means active-high, 0 means active-low. While driving, `irq_o` equals the polarity bit. While released, `irq_o` carries the inverse, which is the inactive level.
- R9: The control register reads the polarity in bit 0 with all other bits 0. Writing it changes only bit 0.
- R10: A read of any other address returns 0xFFFF. A write to any other address changes no register.
- R11: A status bit whose enable is 0 still latches and reads back, but it never drives the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| evt_i | input | N_SRC | Interrupt event lines, rising edge latched |
| reg_addr_i | input | ADDR_W | Register address (control = 0, interrupt = 1 by default) |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe; a read of the interrupt register clears status |
| reg_wdata_i | input | 2*N_SRC | Write data |
| reg_rdata_o | output | 2*N_SRC | Read data, combinational from the address |
| irq_o | output | 1 | Interrupt pin value |
| irq_oe_o | output | 1 | Interrupt pin output-enable; 0 means high impedance |

## Verification
The bench builds the block with its defaults: eight sources, a two-bit address, control at 0 and the interrupt register at 1. With those values every source bit can be swept against both polarities and both enable settings. All 256 enable masks can be swept against a fixed status pattern, and all 256 low-byte write patterns can be shown to leave status untouched. Both unmapped addresses can be read and written. The same-cycle event-and-clear race is checked on one bit while a second bit proves the clear still works.

// File: rtl/irq_pkg.sv
package irq_pkg;

    // Pin ownership states.
    typedef enum logic [0:0] {
        PIN_RELEASED = 1'b0,
        PIN_DRIVING  = 1'b1
    } pin_state_e;

    // Register decode result.
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_IRQ  = 2'd1,
        SEL_NONE = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/irq_status_latch.sv
module irq_status_latch #(
    parameter int N_SRC = 8
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic [N_SRC-1:0] evt_i,
    input  logic             clr_i,
    output logic [N_SRC-1:0] status_o
);

    logic [N_SRC-1:0] evt_prev_q;
    logic [N_SRC-1:0] rise;

    // Previous event level, for edge detection.
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            evt_prev_q <= '0;
        end else begin
            evt_prev_q <= evt_i;
        end
    end

    assign rise = evt_i & ~evt_prev_q;

    // One sticky bit per source; a new edge outranks the clear.
    for (genvar g = 0; g < N_SRC; g++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk_i or negedge rst_n_i) begin
            if (!rst_n_i) begin
                bit_q <= 1'b0;
            end else if (rise[g]) begin
                bit_q <= 1'b1;
            end else if (clr_i) begin
                bit_q <= 1'b0;
            end
        end
        assign status_o[g] = bit_q;
    end

    // R4: a detected edge is visible in status next cycle, even under a clear.
    p_rise_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (|rise) |=> ((status_o & $past(rise)) == $past(rise)));

    // R3: a clear removes every bit that had no new edge.
    p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        clr_i |=> ((status_o & ~$past(rise)) == '0));

    // R2: without a clear, set bits never drop.
    p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !clr_i |=> ((status_o & $past(status_o)) == $past(status_o)));

endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_pkg::*;
#(
    parameter int              N_SRC     = 8,
    parameter int              ADDR_W    = 2,
    parameter logic [ADDR_W-1:0] ADDR_CTRL = 0,
    parameter logic [ADDR_W-1:0] ADDR_IRQ  = 1,
    localparam int             REG_W     = 2 * N_SRC
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic [N_SRC-1:0]  status_i,
    output logic [REG_W-1:0]  rdata_o,
    output logic [N_SRC-1:0]  enable_o,
    output logic              pol_o,
    output logic              clr_o
);

    reg_sel_e         sel;
    logic [N_SRC-1:0] enable_q;
    logic             pol_q;

    // Address decode.
    always_comb begin
        if (addr_i == ADDR_CTRL) begin
            sel = SEL_CTRL;
        end else if (addr_i == ADDR_IRQ) begin
            sel = SEL_IRQ;
        end else begin
            sel = SEL_NONE;
        end
    end

    // Enable half of the interrupt register; the status half is read-only.
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            enable_q <= '0;
        end else if (wr_i && sel == SEL_IRQ) begin
            enable_q <= wdata_i[REG_W-1:N_SRC];
        end
    end

    // Polarity bit in the control register.
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            pol_q <= 1'b0;
        end else if (wr_i && sel == SEL_CTRL) begin
            pol_q <= wdata_i[0];
        end
    end

    // Read mux.
    always_comb begin
        unique case (sel)
            SEL_CTRL: rdata_o = {{(REG_W-1){1'b0}}, pol_q};
            SEL_IRQ:  rdata_o = {enable_q, status_i};
            default:  rdata_o = '1;
        endcase
    end

    assign clr_o    = rd_i && (sel == SEL_IRQ);
    assign enable_o = enable_q;
    assign pol_o    = pol_q;

    // R5: enables only move on a write to the interrupt register.
    p_en_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !(wr_i && addr_i == ADDR_IRQ) |=> $stable(enable_o));

    // R9: polarity only moves on a write to the control register.
    p_pol_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !(wr_i && addr_i == ADDR_CTRL) |=> $stable(pol_o));

endmodule

// File: rtl/irq_pin_fsm.sv
module irq_pin_fsm
    import irq_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic [N_SRC-1:0] status_i,
    input  logic [N_SRC-1:0] enable_i,
    input  logic             pol_i,
    output logic             pin_o,
    output logic             pin_oe_o
);

    pin_state_e state_q;
    pin_state_e state_d;
    logic       pending;

    assign pending = |(status_i & enable_i);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_RELEASED: if (pending)  state_d = PIN_DRIVING;
            PIN_DRIVING:  if (!pending) state_d = PIN_RELEASED;
            default:      state_d = PIN_RELEASED;
        endcase
    end

    // State register.
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            state_q <= PIN_RELEASED;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs.
    always_comb begin
        unique case (state_q)
            PIN_DRIVING: begin
                pin_oe_o = 1'b1;
                pin_o    = pol_i;
            end
            default: begin
                pin_oe_o = 1'b0;
                pin_o    = ~pol_i;
            end
        endcase
    end

    // R6: any enabled pending bit drives the pin on the next edge.
    p_drive_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (|(status_i & enable_i)) |=> pin_oe_o);

    // R7: with nothing enabled and pending, the pin is released on the next edge.
    p_release_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !(|(status_i & enable_i)) |=> !pin_oe_o);

endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl #(
    parameter int              N_SRC     = 8,
    parameter int              ADDR_W    = 2,
    parameter logic [ADDR_W-1:0] ADDR_CTRL = 0,
    parameter logic [ADDR_W-1:0] ADDR_IRQ  = 1,
    localparam int             REG_W     = 2 * N_SRC
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic [N_SRC-1:0]  evt_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic              irq_o,
    output logic              irq_oe_o
);

    logic [N_SRC-1:0] status;
    logic [N_SRC-1:0] enable;
    logic             pol;
    logic             clr;

    irq_status_latch #(.N_SRC(N_SRC)) u_latch (
        .clk_i    (clk_i),
        .rst_n_i  (rst_n_i),
        .evt_i    (evt_i),
        .clr_i    (clr),
        .status_o (status)
    );

    irq_regs #(
        .N_SRC     (N_SRC),
        .ADDR_W    (ADDR_W),
        .ADDR_CTRL (ADDR_CTRL),
        .ADDR_IRQ  (ADDR_IRQ)
    ) u_regs (
        .clk_i    (clk_i),
        .rst_n_i  (rst_n_i),
        .addr_i   (reg_addr_i),
        .wr_i     (reg_wr_i),
        .rd_i     (reg_rd_i),
        .wdata_i  (reg_wdata_i),
        .status_i (status),
        .rdata_o  (reg_rdata_o),
        .enable_o (enable),
        .pol_o    (pol),
        .clr_o    (clr)
    );

    irq_pin_fsm #(.N_SRC(N_SRC)) u_fsm (
        .clk_i    (clk_i),
        .rst_n_i  (rst_n_i),
        .status_i (status),
        .enable_i (enable),
        .pol_i    (pol),
        .pin_o    (irq_o),
        .pin_oe_o (irq_oe_o)
    );

    // R8: the value seen while released is never the active level.
    p_released_level_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !irq_oe_o |-> (irq_o != pol));

endmodule

// File: tb/irq_pin_ctrl_test.sv
`timescale 1ns/1ps
module irq_pin_ctrl_test;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_IRQ  = 2'd1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  evt = '0;
    logic [1:0]  addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;
    logic        irq_oe;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    irq_pin_ctrl uut (
        .clk_i       (clk),
        .rst_n_i     (rst_n),
        .evt_i       (evt),
        .reg_addr_i  (addr),
        .reg_wr_i    (wr),
        .reg_rd_i    (rd),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq),
        .irq_oe_o    (irq_oe)
    );

    task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic reg_write(logic [1:0] a, logic [15:0] d);
        addr = a; wdata = d; wr = 1'b1;
        tick();
        wr = 1'b0;
    endtask

    task automatic reg_read(logic [1:0] a, output logic [15:0] d);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        tick();
        rd = 1'b0;
    endtask

    task automatic peek(logic [1:0] a, output logic [15:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic pulse(logic [7:0] m);
        evt = m;
        tick();
        evt = '0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] d;
        logic [15:0] d2;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        peek(A_CTRL, d); chk("R1 ctrl", d, 16'h0000);
        peek(A_IRQ, d);  chk("R1 irq", d, 16'h0000);
        chk("R1 oe", {15'b0, irq_oe}, 16'h0000);

        // Sweep polarity x source bit x enable (R2 R3 R6 R7 R8 R11)
        for (int p = 0; p < 2; p++) begin
            for (int b = 0; b < 8; b++) begin
                for (int e = 0; e < 2; e++) begin
                    logic [7:0] m;
                    logic [7:0] en;
                    m  = 8'(1 << b);
                    en = (e != 0) ? m : 8'h00;
                    reg_write(A_CTRL, 16'(p));
                    reg_write(A_IRQ, {en, 8'h00});
                    pulse(m);
                    tick();
                    peek(A_IRQ, d);
                    chk("R2 R11 status latched", d, {en, m});
                    chk("R6 oe", {15'b0, irq_oe}, 16'(e));
                    chk("R8 level", {15'b0, irq},
                        16'((e != 0) ? p : (1 - p)));
                    reg_read(A_IRQ, d);
                    tick();
                    peek(A_IRQ, d);
                    chk("R3 cleared", d, {en, 8'h00});
                    chk("R7 released", {15'b0, irq_oe}, 16'h0000);
                    chk("R8 inactive level", {15'b0, irq}, 16'(1 - p));
                end
            end
        end

        // R2: held level does not retrigger after a clear
        reg_write(A_IRQ, 16'h0000);
        evt = 8'h81;
        tick(); tick();
        reg_read(A_IRQ, d);
        chk("R3 read value", d, 16'h0081);
        tick(); tick();
        peek(A_IRQ, d);
        chk("R2 no retrigger", d, 16'h0000);
        evt = '0;
        tick();

        // R4: event edge and clearing read in the same cycle
        pulse(8'h03);
        tick();
        addr = A_IRQ; rd = 1'b1; evt = 8'h02;
        #1 d = rdata;
        chk("R3 pre-race read", d, 16'h0003);
        tick();
        rd = 1'b0; evt = '0;
        peek(A_IRQ, d);
        chk("R4 race bit kept", d, 16'h0002);
        reg_read(A_IRQ, d);

        // R5: the low byte of a write never touches status
        pulse(8'h3C);
        for (int lo = 0; lo < 256; lo++) begin
            reg_write(A_IRQ, {8'hA5, 8'(lo)});
            peek(A_IRQ, d);
            chk("R5 low byte ignored", d, 16'hA53C);
        end

        // R6 R7 R11: every enable mask against status 0x3C
        for (int mk = 0; mk < 256; mk++) begin
            reg_write(A_IRQ, {8'(mk), 8'h00});
            tick();
            chk("R6 R11 mask gate", {15'b0, irq_oe},
                16'(((mk & 8'h3C) != 0) ? 1 : 0));
        end
        reg_read(A_IRQ, d);
        reg_write(A_IRQ, 16'h0000);

        // R9: control register only keeps bit 0
        reg_write(A_CTRL, 16'hFFFE); peek(A_CTRL, d); chk("R9 ctrl 0", d, 16'h0000);
        reg_write(A_CTRL, 16'hFFFF); peek(A_CTRL, d); chk("R9 ctrl 1", d, 16'h0001);

        // R10: unmapped addresses
        for (int a = 2; a < 4; a++) begin
            peek(2'(a), d);
            chk("R10 unmapped read", d, 16'hFFFF);
            reg_write(2'(a), 16'h0000);
            peek(A_CTRL, d);  chk("R10 ctrl untouched", d, 16'h0001);
            peek(A_IRQ, d2);  chk("R10 irq untouched", d2, 16'h0000);
        end

        finish_run();
    end

endmodule